// File: doc/BRIEF.md
# Byte-Bus Parallel Port with H2 Handshake Status

This block is a register-mapped parallel I/O port on a simple byte-wide bus. It has two 8-bit ports, A and B. Each port has a direction register that decides which pins are driven and a data register that supplies the driven values. Reading a port's data address returns the register bit for output pins and the live pin level for input pins. Separate read-only "raw" addresses return the instantaneous pin levels of each port. Reading them latches nothing and changes no state.

Port A has a control register that decides how the H2 handshake line behaves. With control bit 5 clear, H2 is an input and its rising edges set a sticky status flag. With bit 5 set, H2 is driven as a plain level chosen by the submode in bits 7:6 and the select bits 4:3. In that case the sticky flag is held clear. A status register reports the live levels of the four handshake lines together with the H1 level and the H2 flag.

Bus access is synchronous. A write takes effect on the clock edge that samples the write strobe. Read data appears on `rdata` on the edge that samples the read strobe and holds until the next read.

Top module: `pport_top`

## Requirements
- R1: A 1 in a port's direction register (port A at select 2, port B at select 3) sets `*_pin_oe` for that bit. A 0 clears it. `*_pin_out` always equals the port's data register (port A at select 6, port B at select 7).
- R2: Reading a data register address returns `(dir & data) | (~dir & pin)` bit by bit.
- R3: With port A control (select 4) bit 5 at 0, `h2_oe` is 0. A rising edge on `h2_in`, meaning high now and low one clock earlier, sets status bit 1 (H2S) on that clock edge.
- R4: Writing the status address (select 10) with bit 1 at 1 clears H2S. Writing it with bit 1 at 0 leaves H2S unchanged.
- R5: With control bit 5 at 1 and bit 7 at 0 (submode 0x), `h2_oe` is 1. `h2_out` is 0 when bits 4:3 are 00 and 1 for 01, 10 and 11. The 10 and 11 handshake settings drive only a plain asserted level.
- R6: With control bit 5 at 1 and bit 7 at 1 (submode 1x), `h2_oe` is 1 and `h2_out` equals control bit 3. Bit 4 is ignored.
- R7: While control bit 5 is 1, H2S reads 0 and edges on `h2_in` do not set it.
- R8: Status bits 7,6,5,4 show the live levels of H4, H3, H2 and H1. For H2 the level is `h2_out` when driven and `h2_in` otherwise. Status bit 0 equals `h1_in`. Bits 3:2 read 0.
- R9: Select 8 returns `pa_pin_in` and select 9 returns `pb_pin_in`. Reading them changes no register and no pin output.
- R10: Writes to select 8 or 9 are discarded, and no register or output changes.
- R11: A synchronous active-low reset clears general control (select 0), service request (select 1), both direction registers, both control registers (port B at select 5), the port A data register and H2S. The port B data register keeps its value.
- R12: `rdata` updates on the clock edge that samples `rd_en` and holds otherwise. Selects 11 to 15 read 0. Selects 0, 1 and 5 read back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel | input | 4 | Register select |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| pa_pin_in | input | 8 | Port A pin levels |
| pa_pin_out | output | 8 | Port A driven values |
| pa_pin_oe | output | 8 | Port A per-bit output enable |
| pb_pin_in | input | 8 | Port B pin levels |
| pb_pin_out | output | 8 | Port B driven values |
| pb_pin_oe | output | 8 | Port B per-bit output enable |
| h1_in | input | 1 | H1 handshake level |
| h2_in | input | 1 | H2 level when used as an input |
| h2_out | output | 1 | H2 driven level |
| h2_oe | output | 1 | H2 output enable |
| h3_in | input | 1 | H3 handshake level |
| h4_in | input | 1 | H4 handshake level |

## Verification
The bench builds the block with its default width of 8 bits. At that size the whole port A control byte can be swept, all 256 values. This covers every submode and H2 select combination, and for each input-mode value an H2 edge and a clear are applied. Direction, data and pin patterns are swept on both ports in steps across the byte. All eight combinations of H1, H3 and H4 are checked against the status byte. The expected results are computed arithmetically from R2, R5 and R6.

// File: rtl/pport_pkg.sv
// Package: register selects and control bit positions for the parallel port.
// Assumes a 4-bit select and a byte-wide control layout.
package pport_pkg;
    localparam int SEL_W = 4;

    localparam logic [SEL_W-1:0] SEL_GCTL  = 4'd0;
    localparam logic [SEL_W-1:0] SEL_SREQ  = 4'd1;
    localparam logic [SEL_W-1:0] SEL_ADIR  = 4'd2;
    localparam logic [SEL_W-1:0] SEL_BDIR  = 4'd3;
    localparam logic [SEL_W-1:0] SEL_ACTL  = 4'd4;
    localparam logic [SEL_W-1:0] SEL_BCTL  = 4'd5;
    localparam logic [SEL_W-1:0] SEL_ADATA = 4'd6;
    localparam logic [SEL_W-1:0] SEL_BDATA = 4'd7;
    localparam logic [SEL_W-1:0] SEL_ARAW  = 4'd8;
    localparam logic [SEL_W-1:0] SEL_BRAW  = 4'd9;
    localparam logic [SEL_W-1:0] SEL_STAT  = 4'd10;

    localparam int CTL_DIR_BIT = 5;   // 1: H2 driven
    localparam int CTL_SUB_HI  = 7;   // submode upper bit
    localparam int CTL_SEL_HI  = 4;
    localparam int CTL_SEL_LO  = 3;
    localparam int STAT_H2S    = 1;
endpackage

// File: rtl/pport_lane.sv
// Module: one parallel port lane (direction register, data register, readback).
// Assumes the writes are already decoded. CLEAR_DATA picks whether reset
// clears the data register or leaves it untouched.
module pport_lane #(
    parameter int W          = 8,
    parameter bit CLEAR_DATA = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_dir,
    input  logic         wr_data,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe,
    output logic [W-1:0] rd_val
);
    logic [W-1:0] data_q;

    // Direction register, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      dir_q <= '0;
        else if (wr_dir) dir_q <= wdata;
    end

    // Data register: the reset behaviour is chosen per instance.
    generate
        if (CLEAR_DATA) begin : g_clr
            always_ff @(posedge clk) begin
                if (!rst_n)       data_q <= '0;
                else if (wr_data) data_q <= wdata;
            end
        end else begin : g_keep
            always_ff @(posedge clk) begin
                if (wr_data) data_q <= wdata;
            end
        end
    endgenerate

    // Pin drive and mixed readback.
    always_comb begin
        pin_out = data_q;
        pin_oe  = dir_q;
        rd_val  = (dir_q & data_q) | (~dir_q & pin_in);
    end

    assert_dir_to_oe_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dir |=> (pin_oe == $past(wdata)));
endmodule

// File: rtl/pport_h2ctl.sv
// Module: port A control register, H2 pin function decode and H2S flag.
// Assumes h2_in is already synchronous to clk. The previous H2 level is
// sampled every cycle, so an edge is "high now, low one clock earlier".
module pport_h2ctl
    import pport_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_ctl,
    input  logic         wr_stat,
    input  logic [W-1:0] wdata,
    input  logic         h2_in,
    output logic [W-1:0] ctl_q,
    output logic         h2s,
    output logic         h2_out,
    output logic         h2_oe
);
    logic h2_prev;
    logic h2_rise;

    // Control register, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctl_q <= '0;
        else if (wr_ctl) ctl_q <= wdata;
    end

    // Previous H2 level for edge detection.
    always_ff @(posedge clk) begin
        h2_prev <= h2_in;
    end

    assign h2_rise = h2_in & ~h2_prev;

    // H2S: forced clear in output mode, set on an edge, cleared by writing 1.
    always_ff @(posedge clk) begin
        if (!rst_n)                               h2s <= 1'b0;
        else if (ctl_q[CTL_DIR_BIT])              h2s <= 1'b0;
        else if (h2_rise)                         h2s <= 1'b1;
        else if (wr_stat && wdata[STAT_H2S])      h2s <= 1'b0;
    end

    // H2 pin function decode from the submode and the select bits.
    always_comb begin
        h2_oe = ctl_q[CTL_DIR_BIT];
        if (!ctl_q[CTL_DIR_BIT])
            h2_out = 1'b0;
        else if (ctl_q[CTL_SUB_HI])
            h2_out = ctl_q[CTL_SEL_LO];
        else
            h2_out = ctl_q[CTL_SEL_HI] | ctl_q[CTL_SEL_LO];
    end

    assert_h2s_forced_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q[CTL_DIR_BIT] |=> !h2s);
    assert_h2s_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_q[CTL_DIR_BIT] && h2_in && !h2_prev) |=> h2s);
    assert_h2s_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (h2s && !h2_rise && wr_stat && wdata[STAT_H2S]) |=> !h2s);
endmodule

// File: rtl/pport_top.sv
// Module: parallel port top with register decode, status assembly and read mux.
// Assumes single-cycle write and read strobes. Read data is registered
// on the edge that samples rd_en.
module pport_top
    import pport_pkg::*;
#(
    parameter int W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [W-1:0]     wdata,
    output logic [W-1:0]     rdata,
    input  logic [W-1:0]     pa_pin_in,
    output logic [W-1:0]     pa_pin_out,
    output logic [W-1:0]     pa_pin_oe,
    input  logic [W-1:0]     pb_pin_in,
    output logic [W-1:0]     pb_pin_out,
    output logic [W-1:0]     pb_pin_oe,
    input  logic             h1_in,
    input  logic             h2_in,
    output logic             h2_out,
    output logic             h2_oe,
    input  logic             h3_in,
    input  logic             h4_in
);
    logic [W-1:0] gctl_q, sreq_q, bctl_q;
    logic [W-1:0] a_dir, b_dir, a_rd, b_rd, a_ctl;
    logic [W-1:0] status, rd_mux;
    logic         h2s, h2_level;

    // Storage-only registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gctl_q <= '0;
            sreq_q <= '0;
            bctl_q <= '0;
        end else if (wr_en) begin
            if (sel == SEL_GCTL) gctl_q <= wdata;
            if (sel == SEL_SREQ) sreq_q <= wdata;
            if (sel == SEL_BCTL) bctl_q <= wdata;
        end
    end

    pport_lane #(.W(W), .CLEAR_DATA(1'b1)) u_lane_a (
        .clk(clk), .rst_n(rst_n),
        .wr_dir(wr_en && sel == SEL_ADIR), .wr_data(wr_en && sel == SEL_ADATA),
        .wdata(wdata), .pin_in(pa_pin_in), .dir_q(a_dir),
        .pin_out(pa_pin_out), .pin_oe(pa_pin_oe), .rd_val(a_rd)
    );

    pport_lane #(.W(W), .CLEAR_DATA(1'b0)) u_lane_b (
        .clk(clk), .rst_n(rst_n),
        .wr_dir(wr_en && sel == SEL_BDIR), .wr_data(wr_en && sel == SEL_BDATA),
        .wdata(wdata), .pin_in(pb_pin_in), .dir_q(b_dir),
        .pin_out(pb_pin_out), .pin_oe(pb_pin_oe), .rd_val(b_rd)
    );

    pport_h2ctl #(.W(W)) u_h2 (
        .clk(clk), .rst_n(rst_n),
        .wr_ctl(wr_en && sel == SEL_ACTL), .wr_stat(wr_en && sel == SEL_STAT),
        .wdata(wdata), .h2_in(h2_in), .ctl_q(a_ctl), .h2s(h2s),
        .h2_out(h2_out), .h2_oe(h2_oe)
    );

    // Status byte: live handshake levels high, flags low.
    always_comb begin
        h2_level = h2_oe ? h2_out : h2_in;
        status   = '0;
        status[7] = h4_in;
        status[6] = h3_in;
        status[5] = h2_level;
        status[4] = h1_in;
        status[STAT_H2S] = h2s;
        status[0] = h1_in;
    end

    // Read select mux.
    always_comb begin
        case (sel)
            SEL_GCTL:  rd_mux = gctl_q;
            SEL_SREQ:  rd_mux = sreq_q;
            SEL_ADIR:  rd_mux = a_dir;
            SEL_BDIR:  rd_mux = b_dir;
            SEL_ACTL:  rd_mux = a_ctl;
            SEL_BCTL:  rd_mux = bctl_q;
            SEL_ADATA: rd_mux = a_rd;
            SEL_BDATA: rd_mux = b_rd;
            SEL_ARAW:  rd_mux = pa_pin_in;
            SEL_BRAW:  rd_mux = pb_pin_in;
            SEL_STAT:  rd_mux = status;
            default:   rd_mux = '0;
        endcase
    end

    // Registered read data, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end

    assert_raw_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (sel == SEL_ARAW || sel == SEL_BRAW)) |=>
        ($stable(pa_pin_out) && $stable(pa_pin_oe) && $stable(pb_pin_out) && $stable(pb_pin_oe)));
    assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en && $past(rst_n)) |=> $stable(rdata));
endmodule

// File: tb/pport_top_tb.sv
`timescale 1ns/1ps
module pport_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] sel = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = '0, rdata;
    logic [7:0] pa_pin_in = '0, pa_pin_out, pa_pin_oe;
    logic [7:0] pb_pin_in = '0, pb_pin_out, pb_pin_oe;
    logic       h1_in = 0, h2_in = 0, h3_in = 0, h4_in = 0;
    logic       h2_out, h2_oe;
    int         errors = 0, checks = 0;
    bit         done = 0;

    always #2.5 clk = ~clk;

    pport_top u_dut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata),
        .pa_pin_in(pa_pin_in), .pa_pin_out(pa_pin_out), .pa_pin_oe(pa_pin_oe),
        .pb_pin_in(pb_pin_in), .pb_pin_out(pb_pin_out), .pb_pin_oe(pb_pin_oe),
        .h1_in(h1_in), .h2_in(h2_in), .h2_out(h2_out), .h2_oe(h2_oe),
        .h3_in(h3_in), .h4_in(h4_in)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); sel = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk); sel = a; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0; d = rdata;
    endtask

    function automatic logic h2_exp(input logic [7:0] c);
        if (!c[5]) return 1'b0;
        if (c[7])  return c[3];
        return c[4] | c[3];
    endfunction

    initial begin : watchdog
        #(200000 * 5);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] r, s, hold_out, hold_oe;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R11 reset state
        rd(4'd2, r); check("R11 adir after reset", r, 8'h00);
        rd(4'd4, r); check("R11 actl after reset", r, 8'h00);
        check("R11 pa_pin_out after reset", pa_pin_out, 8'h00);
        check("R1 pa_pin_oe after reset", pa_pin_oe, 8'h00);

        // R1 R2 R9 sweep on both ports
        for (int i = 0; i < 256; i += 17) begin
            logic [7:0] d, v, p;
            d = i[7:0]; v = d ^ 8'h5A; p = ~d + 8'h33;
            wr(4'd2, d); wr(4'd6, v); pa_pin_in = p;
            wr(4'd3, ~d); wr(4'd7, ~v); pb_pin_in = ~p;
            @(negedge clk);
            check("R1 pa oe", pa_pin_oe, d);
            check("R1 pa out", pa_pin_out, v);
            check("R1 pb oe", pb_pin_oe, ~d);
            rd(4'd6, r); check("R2 A data readback", r, (d & v) | (~d & p));
            rd(4'd7, r); check("R2 B data readback", r, (~d & ~v) | (d & ~p));
            rd(4'd8, r); check("R9 A raw pins", r, p);
            rd(4'd9, r); check("R9 B raw pins", r, ~p);
            check("R9 raw read leaves pa out", pa_pin_out, v);
            check("R9 raw read leaves pb oe", pb_pin_oe, ~d);
        end

        // R10 writes to raw addresses discarded
        hold_out = pa_pin_out; hold_oe = pa_pin_oe;
        wr(4'd8, 8'hC3); wr(4'd9, 8'h3C);
        check("R10 pa out after raw write", pa_pin_out, hold_out);
        check("R10 pa oe after raw write", pa_pin_oe, hold_oe);
        rd(4'd2, r); check("R10 adir after raw write", r, hold_oe);

        // R3 R4 R5 R6 R7 full control sweep
        for (int c = 0; c < 256; c++) begin
            logic [7:0] cv;
            cv = c[7:0];
            h2_in = 1'b0;
            wr(4'd4, cv);
            wr(4'd10, 8'h02);
            check(cv[5] ? (cv[7] ? "R6 h2_oe" : "R5 h2_oe") : "R3 h2_oe", {7'd0, h2_oe}, {7'd0, cv[5]});
            check(cv[7] ? "R6 h2_out" : "R5 h2_out", {7'd0, h2_out}, {7'd0, h2_exp(cv)});
            @(negedge clk); h2_in = 1'b1;
            rd(4'd10, r);
            check(cv[5] ? "R7 H2S forced clear" : "R3 H2S set on edge", {7'd0, r[1]}, {7'd0, !cv[5]});
            check("R8 H2 level in status", {7'd0, r[5]}, {7'd0, cv[5] ? h2_exp(cv) : 1'b1});
            if (!cv[5]) begin
                wr(4'd10, 8'hFD);
                rd(4'd10, r); check("R4 write 0 keeps H2S", {7'd0, r[1]}, 8'd1);
                wr(4'd10, 8'h02);
                rd(4'd10, r); check("R4 write 1 clears H2S", {7'd0, r[1]}, 8'd0);
            end
        end

        // R8 handshake levels
        wr(4'd4, 8'h00); h2_in = 1'b0; wr(4'd10, 8'h02);
        for (int k = 0; k < 8; k++) begin
            h1_in = k[0]; h3_in = k[1]; h4_in = k[2];
            rd(4'd10, r);
            check("R8 status levels", r, {k[2], k[1], 1'b0, k[0], 3'b000, k[0]});
        end

        // R12 storage and unmapped reads
        wr(4'd0, 8'hA5); wr(4'd1, 8'h69); wr(4'd5, 8'h96);
        rd(4'd0, r); check("R12 gctl readback", r, 8'hA5);
        rd(4'd1, r); check("R12 sreq readback", r, 8'h69);
        rd(4'd5, r); check("R12 bctl readback", r, 8'h96);
        for (int a = 11; a < 16; a++) begin
            rd(a[3:0], r); check("R12 unmapped reads zero", r, 8'h00);
        end
        s = rdata;
        repeat (3) @(negedge clk);
        check("R12 rdata held without rd_en", rdata, s);

        // R11 reset clears all but port B data
        wr(4'd2, 8'hFF); wr(4'd6, 8'h77); wr(4'd3, 8'hFF); wr(4'd7, 8'hE1);
        wr(4'd4, 8'h20);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        pb_pin_in = 8'h00;
        rd(4'd0, r); check("R11 gctl cleared", r, 8'h00);
        rd(4'd1, r); check("R11 sreq cleared", r, 8'h00);
        rd(4'd5, r); check("R11 bctl cleared", r, 8'h00);
        rd(4'd4, r); check("R11 actl cleared", r, 8'h00);
        rd(4'd3, r); check("R11 bdir cleared", r, 8'h00);
        check("R11 pa out cleared", pa_pin_out, 8'h00);
        check("R11 pb data kept", pb_pin_out, 8'hE1);
        wr(4'd3, 8'hFF);
        rd(4'd7, r); check("R11 pb data readback kept", r, 8'hE1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule